// File: doc/BRIEF.md
# Configurable memory map decoder

This block sits between an 8-bit microcontroller core and its memories. Every access it receives carries a 24-bit address. A flag marks the access as a data-space access, a program fetch, or a stack push or pop. The block picks one destination for the access. The destination is one of four on-chip SRAM regions: the 64kB main block, a 256-byte shared buffer, a 1kB data/stack area and an 8kB packet buffer. If none of these applies, the access goes to a slow external memory bus. For an on-chip region the block drives a one-hot chip select, the offset inside the region, a write enable and the write data. For the external bus it runs a transfer of fixed length, with an address and active-low read and write strobes.

Three configuration bits decide where accesses go. The first removes the 64kB main block from the map entirely. The second places the main block in program space instead of data space. The third lets stack accesses use the 1kB area. The configuration is sampled only when an access is accepted, so a transfer that is already running keeps the routing it started with. Read data comes back on one result port. A valid flag marks the cycle in which that data can be used.

Top module: `memmap_dec`

## Requirements
- R1: A data access (prog=0, stack=0) to FFDB00h..FFDBFFh raises int_cs bit 1 in the accept cycle, with int_off = addr[7:0].
- R2: A data access to FFDC00h..FFDFFFh raises int_cs bit 2, with int_off = addr[9:0], whatever the stack-mode bit is.
- R3: When cfg_stk_ext=1, a stack access (req_stack=1, req_prog=0) raises int_cs bit 2 with int_off = addr[9:0]. When cfg_stk_ext=0, a stack access raises no chip select and starts no external strobe, and stk_core is high in the accept cycle.
- R4: A data access to FFE000h..FFFFFFh raises int_cs bit 3, with int_off = addr[12:0].
- R5: A data access to 000000h..00FFFFh raises int_cs bit 0 with int_off = addr[15:0] only when cfg_ram_off=0 and cfg_ram_prog=0. In every other case it becomes an external transfer.
- R6: A program fetch to 000000h..00FFFFh raises int_cs bit 0 when cfg_ram_off=0 and cfg_ram_prog=1. Every other fetch becomes an external read with ext_prog=1. A fetch never writes: req_write is ignored.
- R7: A data access to 010000h..FFDAFFh is always an external transfer, under every configuration.
- R8: At most one int_cs bit is high at any time. While any bit is high, ext_rd_n and ext_wr_n stay 1 and ext_addr stays 0.
- R9: An external transfer holds req_ready low for EXT_CYCLES cycles, starting in the cycle after accept. During those cycles it drives the accepted address on ext_addr, pulls ext_rd_n low for a read or ext_wr_n low for a write, and drives ext_wdata for a write. For a read, ext_rdata sampled in the last strobe cycle appears on rd_data with rd_valid high in the next cycle.
- R10: An on-chip read sets rd_valid for exactly the cycle after accept, and rd_data then equals the selected region's int_rdata byte (region n in bits 8n+7..8n). An on-chip write produces no rd_valid.
- R11: Requests that arrive while a transfer is running are ignored. Configuration changes during a transfer do not alter its address, strobes or returned data.
- R12: During reset: req_ready=1, int_cs=0, rd_valid=0, ext_addr=0, and both strobes are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ram_off | input | 1 | 1 removes the 64kB main block from the map |
| cfg_ram_prog | input | 1 | 1 places the main block in program space |
| cfg_stk_ext | input | 1 | 1 sends stack accesses to the 1kB area |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | High when a request is accepted this cycle |
| req_prog | input | 1 | Access is a program fetch |
| req_stack | input | 1 | Access is a stack push or pop |
| req_write | input | 1 | Access is a write |
| req_addr | input | 24 | Access address |
| req_wdata | input | 8 | Write data |
| int_cs | output | 4 | One-hot region select (0 main, 1 shared, 2 stack, 3 packet) |
| int_off | output | 16 | Offset inside the selected region |
| int_we | output | 1 | Region write enable |
| int_wdata | output | 8 | Region write data |
| int_rdata | input | 32 | Region read data, one byte per region, valid the cycle after select |
| stk_core | output | 1 | Stack access left to the core's own stack |
| ext_addr | output | 24 | External address, 0 when idle |
| ext_rd_n | output | 1 | External read strobe, active low |
| ext_wr_n | output | 1 | External write strobe, active low |
| ext_prog | output | 1 | External transfer is a program fetch |
| ext_wdata | output | 8 | External write data |
| ext_rdata | input | 8 | External read data |
| rd_valid | output | 1 | rd_data holds returned read data |
| rd_data | output | 8 | Returned read data |

## Verification
A wrong routing decision shows up at the ports in the accept cycle itself. The access raises the wrong int_cs bit, or no bit, or a fetch reaches the main block when it should not. An external transfer that should not happen shows as req_ready falling one cycle later. A corrupted transfer counter or captured address shows during the strobe window, as a strobe that is too short or too long or as ext_addr moving. A wrong return-source register shows one cycle after the read, as a rd_data byte from the wrong region.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

  // Destination of one access; values 0..3 double as the chip-select index.
  typedef enum logic [2:0] {
    DST_MAIN = 3'd0,
    DST_SHR  = 3'd1,
    DST_STK  = 3'd2,
    DST_PKT  = 3'd3,
    DST_EXT  = 3'd4,
    DST_NONE = 3'd5
  } dest_e;

  localparam int unsigned NUM_INT = 4;

endpackage

// File: rtl/memmap_window.sv
// Aligned power-of-two address window: hit flag and zero-extended offset.
module memmap_window #(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned OFF_W    = 16,
  parameter int unsigned SPAN_LOG = 8,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [OFF_W-1:0]  off
);

  assign hit = (addr[ADDR_W-1:SPAN_LOG] == BASE[ADDR_W-1:SPAN_LOG]);

  always_comb begin
    off = '0;
    off[SPAN_LOG-1:0] = addr[SPAN_LOG-1:0];
  end

endmodule

// File: rtl/memmap_route.sv
// Combinational routing of one access to a destination and region offset.
module memmap_route
  import memmap_pkg::*;
#(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned OFF_W    = 16,
  parameter logic [ADDR_W-1:0] MAIN_BASE = 24'h000000,
  parameter int unsigned MAIN_LOG = 16,
  parameter logic [ADDR_W-1:0] SHR_BASE  = 24'hFFDB00,
  parameter int unsigned SHR_LOG  = 8,
  parameter logic [ADDR_W-1:0] STK_BASE  = 24'hFFDC00,
  parameter int unsigned STK_LOG  = 10,
  parameter logic [ADDR_W-1:0] PKT_BASE  = 24'hFFE000,
  parameter int unsigned PKT_LOG  = 13
) (
  input  logic              cfg_ram_off,
  input  logic              cfg_ram_prog,
  input  logic              cfg_stk_ext,
  input  logic              req_prog,
  input  logic              req_stack,
  input  logic [ADDR_W-1:0] req_addr,
  output dest_e             dest,
  output logic [OFF_W-1:0]  off
);

  localparam logic [NUM_INT-1:0][ADDR_W-1:0] BASES =
    {PKT_BASE, STK_BASE, SHR_BASE, MAIN_BASE};
  localparam logic [NUM_INT-1:0][7:0] LOGS =
    {8'(PKT_LOG), 8'(STK_LOG), 8'(SHR_LOG), 8'(MAIN_LOG)};

  logic [NUM_INT-1:0]            hit;
  logic [NUM_INT-1:0][OFF_W-1:0] woff;
  logic                          main_live;

  for (genvar gi = 0; gi < NUM_INT; gi++) begin : g_win
    memmap_window #(
      .ADDR_W  (ADDR_W),
      .OFF_W   (OFF_W),
      .SPAN_LOG(int'(LOGS[gi])),
      .BASE    (BASES[gi])
    ) u_win (
      .addr(req_addr),
      .hit (hit[gi]),
      .off (woff[gi])
    );
  end

  assign main_live = hit[DST_MAIN] && !cfg_ram_off;

  always_comb begin
    dest = DST_EXT;
    if (req_prog) begin
      if (main_live && cfg_ram_prog) dest = DST_MAIN;
    end else if (req_stack) begin
      dest = cfg_stk_ext ? DST_STK : DST_NONE;
    end else if (hit[DST_SHR]) begin
      dest = DST_SHR;
    end else if (hit[DST_STK]) begin
      dest = DST_STK;
    end else if (hit[DST_PKT]) begin
      dest = DST_PKT;
    end else if (main_live && !cfg_ram_prog) begin
      dest = DST_MAIN;
    end
  end

  always_comb begin
    off = '0;
    if (!dest[2]) off = woff[dest[1:0]];
  end

endmodule

// File: rtl/memmap_xfer.sv
// Transfer sequencer: external strobe window, capture and read-data return.
module memmap_xfer
  import memmap_pkg::*;
#(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned EXT_CYCLES = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           accept,
  input  dest_e                          dest,
  input  logic [ADDR_W-1:0]              addr,
  input  logic                           write_eff,
  input  logic                           prog,
  input  logic [DATA_W-1:0]              wdata,
  input  logic [NUM_INT-1:0][DATA_W-1:0] int_rdata,
  input  logic [DATA_W-1:0]              ext_rdata,
  output logic                           idle,
  output logic [ADDR_W-1:0]              ext_addr,
  output logic                           ext_rd_n,
  output logic                           ext_wr_n,
  output logic                           ext_prog,
  output logic [DATA_W-1:0]              ext_wdata,
  output logic                           rd_valid,
  output logic [DATA_W-1:0]              rd_data
);

  localparam int unsigned CNT_W = (EXT_CYCLES > 1) ? $clog2(EXT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(EXT_CYCLES - 1);

  typedef enum logic {ST_IDLE, ST_EXT} st_e;

  st_e               st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              rdv_q, rdv_d;
  dest_e             src_q, src_d;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q, prog_q;
  logic [DATA_W-1:0] wdata_q, edat_q;
  logic              on_ext, last_ext, start_ext;

  assign on_ext    = (st_q == ST_EXT);
  assign last_ext  = on_ext && (cnt_q == CNT_LAST);
  assign start_ext = accept && (dest == DST_EXT);

  // next state
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    rdv_d = 1'b0;
    src_d = src_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_ext) begin
          st_d  = ST_EXT;
          cnt_d = '0;
        end else if (accept && !dest[2] && !write_eff) begin
          rdv_d = 1'b1;
          src_d = dest;
        end
      end
      ST_EXT: begin
        if (last_ext) begin
          st_d  = ST_IDLE;
          rdv_d = !wr_q;
          src_d = DST_EXT;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      rdv_q <= 1'b0;
      src_q <= DST_MAIN;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      rdv_q <= rdv_d;
      src_q <= src_d;
    end
  end

  // request capture, enabled at the start of an external transfer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wr_q    <= 1'b0;
      prog_q  <= 1'b0;
      wdata_q <= '0;
    end else if (start_ext) begin
      addr_q  <= addr;
      wr_q    <= write_eff;
      prog_q  <= prog;
      wdata_q <= wdata;
    end
  end

  // external read data, enabled in the last strobe cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edat_q <= '0;
    end else if (last_ext) begin
      edat_q <= ext_rdata;
    end
  end

  assign idle      = !on_ext;
  assign ext_addr  = on_ext ? addr_q : '0;
  assign ext_rd_n  = !(on_ext && !wr_q);
  assign ext_wr_n  = !(on_ext && wr_q);
  assign ext_prog  = on_ext && prog_q;
  assign ext_wdata = (on_ext && wr_q) ? wdata_q : '0;
  assign rd_valid  = rdv_q;
  assign rd_data   = (src_q == DST_EXT) ? edat_q : int_rdata[src_q[1:0]];

endmodule

// File: rtl/memmap_dec.sv
module memmap_dec
  import memmap_pkg::*;
#(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned OFF_W      = 16,
  parameter int unsigned EXT_CYCLES = 3,
  parameter logic [ADDR_W-1:0] MAIN_BASE = 24'h000000,
  parameter int unsigned MAIN_LOG   = 16,
  parameter logic [ADDR_W-1:0] SHR_BASE  = 24'hFFDB00,
  parameter int unsigned SHR_LOG    = 8,
  parameter logic [ADDR_W-1:0] STK_BASE  = 24'hFFDC00,
  parameter int unsigned STK_LOG    = 10,
  parameter logic [ADDR_W-1:0] PKT_BASE  = 24'hFFE000,
  parameter int unsigned PKT_LOG    = 13
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_ram_off,
  input  logic                        cfg_ram_prog,
  input  logic                        cfg_stk_ext,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_prog,
  input  logic                        req_stack,
  input  logic                        req_write,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [DATA_W-1:0]           req_wdata,
  output logic [NUM_INT-1:0]          int_cs,
  output logic [OFF_W-1:0]            int_off,
  output logic                        int_we,
  output logic [DATA_W-1:0]           int_wdata,
  input  logic [NUM_INT*DATA_W-1:0]   int_rdata,
  output logic                        stk_core,
  output logic [ADDR_W-1:0]           ext_addr,
  output logic                        ext_rd_n,
  output logic                        ext_wr_n,
  output logic                        ext_prog,
  output logic [DATA_W-1:0]           ext_wdata,
  input  logic [DATA_W-1:0]           ext_rdata,
  output logic                        rd_valid,
  output logic [DATA_W-1:0]           rd_data
);

  logic [1:0]       rsync_q;
  logic             rst_sync_n;
  dest_e            dest;
  logic [OFF_W-1:0] off_sel;
  logic             idle, accept, to_int, write_eff;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  memmap_route #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W),
    .MAIN_BASE(MAIN_BASE), .MAIN_LOG(MAIN_LOG),
    .SHR_BASE(SHR_BASE),   .SHR_LOG(SHR_LOG),
    .STK_BASE(STK_BASE),   .STK_LOG(STK_LOG),
    .PKT_BASE(PKT_BASE),   .PKT_LOG(PKT_LOG)
  ) u_route (
    .cfg_ram_off (cfg_ram_off),
    .cfg_ram_prog(cfg_ram_prog),
    .cfg_stk_ext (cfg_stk_ext),
    .req_prog    (req_prog),
    .req_stack   (req_stack),
    .req_addr    (req_addr),
    .dest        (dest),
    .off         (off_sel)
  );

  assign accept    = req_valid && idle;
  assign to_int    = accept && !dest[2];
  assign write_eff = req_write && !req_prog;

  for (genvar gi = 0; gi < NUM_INT; gi++) begin : g_cs
    assign int_cs[gi] = to_int && (dest[1:0] == 2'(gi));
  end

  assign req_ready = idle;
  assign int_off   = to_int ? off_sel : '0;
  assign int_we    = to_int && write_eff;
  assign int_wdata = int_we ? req_wdata : '0;
  assign stk_core  = accept && (dest == DST_NONE);

  memmap_xfer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EXT_CYCLES(EXT_CYCLES)
  ) u_xfer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .accept   (accept),
    .dest     (dest),
    .addr     (req_addr),
    .write_eff(write_eff),
    .prog     (req_prog),
    .wdata    (req_wdata),
    .int_rdata(int_rdata),
    .ext_rdata(ext_rdata),
    .idle     (idle),
    .ext_addr (ext_addr),
    .ext_rd_n (ext_rd_n),
    .ext_wr_n (ext_wr_n),
    .ext_prog (ext_prog),
    .ext_wdata(ext_wdata),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/memmap_dec_chk.sv
module memmap_dec_chk #(
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned NUM_INT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic [NUM_INT-1:0] int_cs,
  input logic               int_we,
  input logic [ADDR_W-1:0]  ext_addr,
  input logic               ext_rd_n,
  input logic               ext_wr_n,
  input logic               rd_valid
);

  // R8
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(int_cs));

  // R8
  int_quiet_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|int_cs) |-> (ext_rd_n && ext_wr_n && ext_addr == '0));

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_rd_n) |-> ext_wr_n);

  // R9
  ext_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready) |=> (req_ready || $stable(ext_addr)));

  // R10
  int_rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|int_cs) && !int_we) |=> rd_valid);

  // R11
  busy_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready) |-> (int_cs == '0));

endmodule

bind memmap_dec memmap_dec_chk #(.ADDR_W(ADDR_W), .NUM_INT(memmap_pkg::NUM_INT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .int_cs   (int_cs),
  .int_we   (int_we),
  .ext_addr (ext_addr),
  .ext_rd_n (ext_rd_n),
  .ext_wr_n (ext_wr_n),
  .rd_valid (rd_valid)
);

// File: tb/memmap_dec_tb.sv
module memmap_dec_tb;
  localparam int AW = 24, DW = 8, OW = 16, NINT = 4, NCYC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic cfg_ram_off = 1'b0, cfg_ram_prog = 1'b0, cfg_stk_ext = 1'b0;
  logic req_valid = 1'b0, req_prog = 1'b0, req_stack = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, int_we, stk_core, ext_rd_n, ext_wr_n, ext_prog, rd_valid;
  logic [NINT-1:0] int_cs;
  logic [OW-1:0] int_off;
  logic [DW-1:0] int_wdata, ext_wdata, ext_rdata, rd_data;
  logic [NINT*DW-1:0] int_rdata;
  logic [AW-1:0] ext_addr;

  int n_chk = 0, n_err = 0;

  memmap_dec #(.EXT_CYCLES(NCYC)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_ram_off(cfg_ram_off), .cfg_ram_prog(cfg_ram_prog), .cfg_stk_ext(cfg_stk_ext),
    .req_valid(req_valid), .req_ready(req_ready), .req_prog(req_prog),
    .req_stack(req_stack), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .int_cs(int_cs), .int_off(int_off), .int_we(int_we),
    .int_wdata(int_wdata), .int_rdata(int_rdata), .stk_core(stk_core),
    .ext_addr(ext_addr), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
    .ext_prog(ext_prog), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic logic [7:0] pat(int i, logic [15:0] o);
    return o[7:0] ^ o[15:8] ^ 8'((i + 1) * 17);
  endfunction

  function automatic logic [7:0] epat(logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  // behavioural region memories: registered read of a computed pattern
  logic [DW-1:0] rdq [NINT];
  always_ff @(posedge clk)
    for (int i = 0; i < NINT; i++)
      if (int_cs[i]) rdq[i] <= pat(i, int_off);
  assign int_rdata = {rdq[3], rdq[2], rdq[1], rdq[0]};
  assign ext_rdata = epat(ext_addr);

  // 0 main, 1 shared, 2 stack area, 3 packet, 4 external, 5 core stack
  function automatic int exp_dest(bit prog, bit stk, logic [23:0] a, bit off, bit prg, bit sx);
    if (prog) return (a <= 24'h00FFFF && !off && prg) ? 0 : 4;
    if (stk) return sx ? 2 : 5;
    if (a >= 24'hFFDB00 && a <= 24'hFFDBFF) return 1;
    if (a >= 24'hFFDC00 && a <= 24'hFFDFFF) return 2;
    if (a >= 24'hFFE000) return 3;
    if (a <= 24'h00FFFF && !off && !prg) return 0;
    return 4;
  endfunction

  function automatic logic [23:0] omask(int e);
    case (e)
      0: return 24'hFFFF;
      1: return 24'h00FF;
      2: return 24'h03FF;
      default: return 24'h1FFF;
    endcase
  endfunction

  function automatic string rtag(bit prog, bit stk, int e, logic [23:0] a);
    if (prog) return "R6";
    if (stk) return "R3";
    if (e == 1) return "R1";
    if (e == 2) return "R2";
    if (e == 3) return "R4";
    if (a >= 24'h010000) return "R7";
    return "R5";
  endfunction

  task automatic chk(string t, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  task automatic access(bit prog, bit stk, bit wr, logic [23:0] a, logic [7:0] wd);
    int e;
    bit we_eff;
    string t;
    logic [15:0] o;
    e = exp_dest(prog, stk, a, cfg_ram_off, cfg_ram_prog, cfg_stk_ext);
    we_eff = wr && !prog;
    t = rtag(prog, stk, e, a);
    o = 16'(a & omask(e));
    @(negedge clk);
    req_valid = 1'b1; req_prog = prog; req_stack = stk; req_write = wr;
    req_addr = a; req_wdata = wd;
    #1;
    chk(t, "ready", req_ready, 1);
    if (e < 4) begin
      chk(t, "cs", int_cs, 32'(1 << e));
      chk(t, "off", int_off, o);
      chk(t, "we", int_we, we_eff);
      if (we_eff) chk(t, "wdata", int_wdata, wd);
      chk("R8", "ext_idle", {ext_rd_n, ext_wr_n, ext_addr == 24'h0}, 3'b111);
    end else begin
      chk(t, "cs", int_cs, 0);
    end
    chk(t, "stk_core", stk_core, (e == 5));
    @(negedge clk);
    req_valid = 1'b0;
    if (e < 4) begin
      chk("R10", "rd_valid", rd_valid, !we_eff);
      if (!we_eff) chk("R10", "rd_data", rd_data, pat(e, o));
    end else if (e == 5) begin
      chk(t, "rd_valid", rd_valid, 0);
      chk(t, "strobes", {req_ready, ext_rd_n, ext_wr_n}, 3'b111);
    end else begin
      for (int k = 1; k <= NCYC; k++) begin
        chk("R9", "ready", req_ready, 0);
        chk(t, "ext_addr", ext_addr, a);
        chk("R9", "rd_n", ext_rd_n, we_eff);
        chk("R9", "wr_n", ext_wr_n, !we_eff);
        chk(t, "ext_prog", ext_prog, prog);
        if (we_eff) chk("R9", "ext_wdata", ext_wdata, wd);
        chk("R9", "cs", int_cs, 0);
        @(negedge clk);
      end
      chk("R9", "ready_back", req_ready, 1);
      chk("R9", "rd_valid", rd_valid, !we_eff);
      if (!we_eff) chk("R9", "rd_data", rd_data, epat(a));
    end
  endtask

  logic [23:0] addrs [14] = '{24'h000000, 24'h000001, 24'h00FFFF, 24'h010000,
                              24'h123456, 24'hFFDAFF, 24'hFFDB00, 24'hFFDB7F,
                              24'hFFDBFF, 24'hFFDC00, 24'hFFDFFF, 24'hFFE000,
                              24'hFFF00F, 24'hFFFFFF};

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", "ready", req_ready, 1);
    chk("R12", "cs", int_cs, 0);
    chk("R12", "rd_valid", rd_valid, 0);
    chk("R12", "ext_addr", ext_addr, 0);
    chk("R12", "strobes", {ext_rd_n, ext_wr_n}, 2'b11);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      cfg_ram_off = c[0]; cfg_ram_prog = c[1]; cfg_stk_ext = c[2];
      for (int j = 0; j < 14; j++) begin
        access(0, 0, 0, addrs[j], 8'h00);
        access(0, 0, 1, addrs[j], addrs[j][7:0] ^ 8'hC3);
        access(1, 0, 0, addrs[j], 8'h00);
        access(1, 0, 1, addrs[j], 8'hA5);
        access(0, 1, 0, addrs[j], 8'h00);
        access(0, 1, 1, addrs[j], 8'h3C);
      end
    end

    // R11: configuration flips and a competing request during a transfer
    @(negedge clk);
    cfg_ram_off = 1'b1; cfg_ram_prog = 1'b0; cfg_stk_ext = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_prog = 1'b0; req_stack = 1'b0; req_write = 1'b0;
    req_addr = 24'h000010;
    @(negedge clk);
    req_addr = 24'hFFDB10; cfg_ram_off = 1'b0; cfg_stk_ext = 1'b1;
    for (int k = 1; k <= NCYC; k++) begin
      #1;
      chk("R11", "cs_busy", int_cs, 0);
      chk("R11", "ext_addr", ext_addr, 24'h000010);
      chk("R11", "rd_n", ext_rd_n, 0);
      if (k == NCYC) req_valid = 1'b0;
      @(negedge clk);
    end
    chk("R11", "rd_valid", rd_valid, 1);
    chk("R11", "rd_data", rd_data, epat(24'h000010));
    @(negedge clk);
    chk("R11", "no_extra", {req_ready, ext_rd_n, rd_valid}, 3'b110);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule